// File: doc/BRIEF.md
# Subchannel Function Control Unit

This unit holds the status word of one I/O subchannel and arbitrates the commands that software issues against it. It keeps three groups of control bits: function bits (start, halt, clear), activity bits (resume pending, start pending, halt pending, clear pending, suspended, subchannel active, device active) and status bits (alert, intermediate, primary, secondary, status pending). Each command is checked against the current bits. The unit then returns a 2-bit condition code and updates the word.

An execution engine outside the block runs the channel program. It reports one outcome per start or resume: done, reject, data error, program error, suspend or busy. The engine also drives a level that says the subchannel and device are active. When status becomes pending, the unit raises an interrupt request that carries a subchannel ID word.

The interrupt request is a valid/ready stream. Once `irq_valid` rises it stays high, and `irq_id` holds its value, until a cycle in which `irq_ready` is high. Commands, outcomes and configuration are plain signals with no back-pressure. A command is taken in every cycle in which `cmd_valid` is high.

Top module: `scu_fcu`

## Requirements
- R1: After reset, every function, activity and status bit is 0, the device status, channel status, deferred code and sense byte are 0, and `rsp_valid` and `irq_valid` are low.
- R2: Each cycle with `cmd_valid` high produces `rsp_valid` high exactly one cycle later, with `rsp_cc` in the next cycle. Codes are 0 accepted, 1 status pending, 2 busy and 3 not operational. Code 3, with no state change, is returned for any command when the subchannel is not both device-valid and enabled, and for op codes 6 and 7. Ops are 0 start, 1 resume, 2 halt, 3 clear, 4 cancel and 5 test-status.
- R3: Start returns 1 if status is pending and 2 if any function bit (fctl bit0 start, bit1 halt, bit2 clear) is set. If accepted, it sets start function and start pending (actl bit1).
- R4: An accepted start whose path mask has bit 7 clear sets deferred code 3 and status alert+pending (stctl bit4 alert, bit0 pending).
- R5: Outcome done (0) clears start pending, sets status to primary(bit2)+secondary(bit1)+pending, and sets device status to 0x0C (channel end 0x08 plus device end 0x04).
- R6: Outcome reject (1) sets device status 0x02 and sense byte 0x80. Data error (2) sets channel status 0x08. Program error (3) sets 0x20. All three clear start pending and set status to primary+secondary+alert+pending.
- R7: Outcome suspend (4) clears start pending, sets suspended (actl bit4) and sets status to intermediate(bit3)+pending. Outcome busy (5) sets deferred code 1 and status alert+pending. Outcomes are ignored unless start function is set, start or resume is pending, status is not pending and `cmd_valid` is low. Any outcome that is taken first clears resume pending and suspended.
- R8: Resume returns 1 if status is pending. It returns 2 unless the start function is the only function bit, resume pending (actl bit0) is clear and the subchannel is suspended. If accepted, it sets resume pending.
- R9: Halt returns 1 when status is pending alone or when alert, primary or secondary is set, and 2 when halt or clear function is set. If accepted, it sets halt function, clears start function and sets pending. Device status becomes 0x04 when subchannel or device is active (actl bit5/bit6) or when neither start pending nor suspended is set.
- R10: Clear is always accepted on an operational subchannel. Function becomes clear only, activity becomes 0, status becomes pending only, and device status, channel status and deferred code become 0.
- R11: Cancel returns 2 unless start is the only function, start or resume is pending or the subchannel is suspended, and subchannel active is clear. Otherwise it returns 1 if any status bit is set. If accepted, it clears start function, start pending, resume pending and suspended.
- R12: Test-status returns 1 and changes nothing when status is not pending. Otherwise it returns 0 and clears the status bits. If the status was intermediate+pending alone and the halt function is not set, it clears only resume pending as well. In every other case it also clears function, activity, device status, channel status, deferred code and sense byte.
- R13: A rise of status pending raises `irq_valid`, held until `irq_ready`. The ID is (cssid<<8)|0x8|(ssid<<1)|1 with `cfg_multi_css` high, and (ssid<<1)|1 otherwise, taken at the rise.
- R14: Activity bits 5 and 6 equal `exec_active` ANDed with (start pending OR resume pending) of the updated word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dev_valid | input | 1 | Subchannel has a valid device number |
| cfg_enabled | input | 1 | Subchannel enabled |
| cfg_multi_css | input | 1 | Multiple channel subsystems enabled (ID format) |
| cfg_cssid | input | CSS_W | Channel subsystem ID |
| cfg_ssid | input | SS_W | Subchannel set ID |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command op code |
| cmd_lpm | input | PATH_W | Logical path mask for start |
| rsp_valid | output | 1 | Condition code valid |
| rsp_cc | output | 2 | Condition code |
| exec_valid | input | 1 | Execution outcome present |
| exec_result | input | 3 | Execution outcome code |
| exec_active | input | 1 | Engine reports subchannel and device active |
| sw_fctl | output | 3 | Function bits |
| sw_actl | output | 7 | Activity bits |
| sw_stctl | output | 5 | Status bits |
| sw_dstat | output | 8 | Device status |
| sw_cstat | output | 8 | Channel status |
| sw_dcc | output | 2 | Deferred condition code |
| sw_sense0 | output | 8 | Sense byte 0 |
| irq_valid | output | 1 | Interrupt request valid |
| irq_ready | input | 1 | Interrupt request taken |
| irq_id | output | CSS_W+8 | Subchannel ID word |

## Verification
The assertions check properties that hold on every cycle: a response follows each command one cycle later, a non-operational subchannel returns code 3 and keeps its function bits, clear always leaves the clear-only word, test-status with nothing pending returns code 1, normal completion sets the final status, and a stalled interrupt request keeps its ID. The bench scenarios cover what depends on sequences. These include the suspend, intermediate test-status and resume path, halt on a suspended subchannel, outcomes that are dropped because a command arrived in the same cycle or status was pending, cancel blocked by engine activity, and the switch of ID format between the single and multiple subsystem settings.

// File: rtl/scu_pkg.sv
`timescale 1ns/1ps
package scu_pkg;
  // command op codes
  localparam logic [2:0] OP_START  = 3'd0;
  localparam logic [2:0] OP_RESUME = 3'd1;
  localparam logic [2:0] OP_HALT   = 3'd2;
  localparam logic [2:0] OP_CLEAR  = 3'd3;
  localparam logic [2:0] OP_CANCEL = 3'd4;
  localparam logic [2:0] OP_TEST   = 3'd5;

  // execution outcomes
  localparam logic [2:0] RS_DONE = 3'd0;
  localparam logic [2:0] RS_REJ  = 3'd1;
  localparam logic [2:0] RS_DERR = 3'd2;
  localparam logic [2:0] RS_PERR = 3'd3;
  localparam logic [2:0] RS_SUSP = 3'd4;
  localparam logic [2:0] RS_BUSY = 3'd5;

  // condition codes
  localparam logic [1:0] CC_OK   = 2'd0;
  localparam logic [1:0] CC_PEND = 2'd1;
  localparam logic [1:0] CC_BUSY = 2'd2;
  localparam logic [1:0] CC_NOP  = 2'd3;

  // function bit positions
  localparam int FN_START = 0;
  localparam int FN_HALT  = 1;
  localparam int FN_CLEAR = 2;

  // activity bit positions
  localparam int AC_RES = 0;
  localparam int AC_STP = 1;
  localparam int AC_SUS = 4;
  localparam int AC_SCA = 5;
  localparam int AC_DVA = 6;

  // status bit values
  localparam logic [4:0] ST_PEND = 5'b00001;
  localparam logic [4:0] ST_SEC  = 5'b00010;
  localparam logic [4:0] ST_PRI  = 5'b00100;
  localparam logic [4:0] ST_INT  = 5'b01000;
  localparam logic [4:0] ST_ALR  = 5'b10000;

  localparam logic [7:0] DS_CE   = 8'h08;
  localparam logic [7:0] DS_DE   = 8'h04;
  localparam logic [7:0] DS_UC   = 8'h02;
  localparam logic [7:0] CS_PCHK = 8'h20;
  localparam logic [7:0] CS_DCHK = 8'h08;
  localparam logic [7:0] SENSE_REJ = 8'h80;

  typedef struct packed {
    logic [2:0] fctl;
    logic [6:0] actl;
    logic [4:0] stctl;
    logic [7:0] dstat;
    logic [7:0] cstat;
    logic [1:0] dcc;
    logic [7:0] sense0;
  } sw_t;
endpackage

// File: rtl/scu_cc_eval.sv
`timescale 1ns/1ps
module scu_cc_eval
  import scu_pkg::*;
(
  input  logic       oper_ok,
  input  logic [2:0] op,
  input  logic [2:0] fctl,
  input  logic [4:0] stctl,
  input  logic       act_res,
  input  logic       act_stp,
  input  logic       act_sus,
  input  logic       act_sca,
  output logic [1:0] cc
);
  logic start_only;
  logic halt_stat_block;

  assign start_only      = (fctl == 3'b001);
  assign halt_stat_block = (stctl == ST_PEND) || |(stctl & (ST_PRI | ST_SEC | ST_ALR));

  always_comb begin
    cc = CC_OK;
    if (!oper_ok) begin
      cc = CC_NOP;
    end else begin
      case (op)
        OP_START:  if (stctl[0]) cc = CC_PEND;
                   else if (|fctl) cc = CC_BUSY;
        OP_RESUME: if (stctl[0]) cc = CC_PEND;
                   else if (!start_only || act_res || !act_sus) cc = CC_BUSY;
        OP_HALT:   if (halt_stat_block) cc = CC_PEND;
                   else if (fctl[FN_HALT] || fctl[FN_CLEAR]) cc = CC_BUSY;
        OP_CLEAR:  cc = CC_OK;
        OP_CANCEL: if (!start_only || !(act_res || act_stp || act_sus) || act_sca) cc = CC_BUSY;
                   else if (|stctl) cc = CC_PEND;
        OP_TEST:   if (!stctl[0]) cc = CC_PEND;
        default:   cc = CC_NOP;
      endcase
    end
  end
endmodule

// File: rtl/scu_next_state.sv
`timescale 1ns/1ps
module scu_next_state
  import scu_pkg::*;
#(
  parameter int PATH_W = 8,
  parameter logic [PATH_W-1:0] PATH_SEL = 8'h80
) (
  input  logic              cmd_fire,
  input  logic [2:0]        op,
  input  logic [PATH_W-1:0] lpm,
  input  logic [1:0]        cc,
  input  logic              exec_valid,
  input  logic [2:0]        exec_result,
  input  logic              exec_active,
  input  sw_t               cur,
  output sw_t               nxt
);
  logic outcome_ok;
  logic inter_only;

  assign outcome_ok = exec_valid && !cmd_fire && cur.fctl[FN_START] &&
                      (cur.actl[AC_STP] || cur.actl[AC_RES]) && !cur.stctl[0] &&
                      (exec_result <= RS_BUSY);
  assign inter_only = (cur.stctl == (ST_INT | ST_PEND)) && !cur.fctl[FN_HALT];

  always_comb begin
    nxt = cur;
    if (cmd_fire) begin
      if (cc == CC_OK) begin
        case (op)
          OP_START: begin
            nxt.fctl[FN_START] = 1'b1;
            nxt.actl[AC_STP]   = 1'b1;
            if ((lpm & PATH_SEL) == '0) begin
              nxt.dcc   = 2'd3;
              nxt.stctl = ST_ALR | ST_PEND;
            end
          end
          OP_RESUME: nxt.actl[AC_RES] = 1'b1;
          OP_HALT: begin
            nxt.fctl[FN_HALT]  = 1'b1;
            nxt.fctl[FN_START] = 1'b0;
            nxt.stctl          = cur.stctl | ST_PEND;
            if (cur.actl[AC_SCA] || cur.actl[AC_DVA] ||
                !(cur.actl[AC_STP] || cur.actl[AC_SUS]))
              nxt.dstat = DS_DE;
          end
          OP_CLEAR: begin
            nxt.fctl  = 3'b100;
            nxt.actl  = '0;
            nxt.stctl = ST_PEND;
            nxt.dstat = '0;
            nxt.cstat = '0;
            nxt.dcc   = '0;
          end
          OP_CANCEL: begin
            nxt.fctl[FN_START] = 1'b0;
            nxt.actl[AC_RES]   = 1'b0;
            nxt.actl[AC_STP]   = 1'b0;
            nxt.actl[AC_SUS]   = 1'b0;
          end
          OP_TEST: begin
            nxt.stctl = '0;
            if (inter_only) begin
              nxt.actl[AC_RES] = 1'b0;
            end else begin
              nxt.fctl   = '0;
              nxt.actl   = '0;
              nxt.dstat  = '0;
              nxt.cstat  = '0;
              nxt.dcc    = '0;
              nxt.sense0 = '0;
            end
          end
          default: ;
        endcase
      end
    end else if (outcome_ok) begin
      nxt.actl[AC_RES] = 1'b0;
      nxt.actl[AC_SUS] = 1'b0;
      case (exec_result)
        RS_DONE: begin
          nxt.actl[AC_STP] = 1'b0;
          nxt.stctl = ST_PRI | ST_SEC | ST_PEND;
          nxt.dstat = DS_CE | DS_DE;
        end
        RS_REJ: begin
          nxt.actl[AC_STP] = 1'b0;
          nxt.stctl  = ST_PRI | ST_SEC | ST_ALR | ST_PEND;
          nxt.dstat  = DS_UC;
          nxt.sense0 = SENSE_REJ;
        end
        RS_DERR, RS_PERR: begin
          nxt.actl[AC_STP] = 1'b0;
          nxt.stctl = ST_PRI | ST_SEC | ST_ALR | ST_PEND;
          nxt.cstat = (exec_result == RS_DERR) ? CS_DCHK : CS_PCHK;
        end
        RS_SUSP: begin
          nxt.actl[AC_STP] = 1'b0;
          nxt.actl[AC_SUS] = 1'b1;
          nxt.stctl = ST_INT | ST_PEND;
        end
        default: begin
          nxt.dcc   = 2'd1;
          nxt.stctl = ST_ALR | ST_PEND;
        end
      endcase
    end
    nxt.actl[AC_SCA] = exec_active && (nxt.actl[AC_STP] || nxt.actl[AC_RES]);
    nxt.actl[AC_DVA] = exec_active && (nxt.actl[AC_STP] || nxt.actl[AC_RES]);
  end
endmodule

// File: rtl/scu_irq_port.sv
`timescale 1ns/1ps
module scu_irq_port #(
  parameter int CSS_W = 8,
  parameter int SS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise,
  input  logic              multi_css,
  input  logic [CSS_W-1:0]  cssid,
  input  logic [SS_W-1:0]   ssid,
  input  logic              irq_ready,
  output logic              irq_valid,
  output logic [CSS_W+7:0]  irq_id
);
  localparam int ID_W = CSS_W + 8;

  logic [ID_W-1:0] id_word;

  always_comb begin
    id_word = ID_W'({ssid, 1'b1});
    if (multi_css)
      id_word = id_word | ID_W'(8) | {cssid, 8'h00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_id    <= '0;
    end else if (raise) begin
      irq_valid <= 1'b1;
      irq_id    <= id_word;
    end else if (irq_valid && irq_ready) begin
      irq_valid <= 1'b0;
    end
  end

  // R13
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready && !raise) |=> (irq_valid && $stable(irq_id)));
endmodule

// File: rtl/scu_fcu.sv
`timescale 1ns/1ps
module scu_fcu
  import scu_pkg::*;
#(
  parameter int CSS_W  = 8,
  parameter int SS_W   = 2,
  parameter int PATH_W = 8,
  parameter logic [PATH_W-1:0] PATH_SEL = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dev_valid,
  input  logic              cfg_enabled,
  input  logic              cfg_multi_css,
  input  logic [CSS_W-1:0]  cfg_cssid,
  input  logic [SS_W-1:0]   cfg_ssid,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [PATH_W-1:0] cmd_lpm,
  output logic              rsp_valid,
  output logic [1:0]        rsp_cc,
  input  logic              exec_valid,
  input  logic [2:0]        exec_result,
  input  logic              exec_active,
  output logic [2:0]        sw_fctl,
  output logic [6:0]        sw_actl,
  output logic [4:0]        sw_stctl,
  output logic [7:0]        sw_dstat,
  output logic [7:0]        sw_cstat,
  output logic [1:0]        sw_dcc,
  output logic [7:0]        sw_sense0,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [CSS_W+7:0]  irq_id
);
  sw_t        cur, nxt;
  logic [1:0] cc;
  logic       oper_ok;
  logic       pend_rise;

  assign oper_ok = cfg_dev_valid && cfg_enabled;

  scu_cc_eval u_cc (
    .oper_ok (oper_ok),
    .op      (cmd_op),
    .fctl    (cur.fctl),
    .stctl   (cur.stctl),
    .act_res (cur.actl[AC_RES]),
    .act_stp (cur.actl[AC_STP]),
    .act_sus (cur.actl[AC_SUS]),
    .act_sca (cur.actl[AC_SCA]),
    .cc      (cc)
  );

  scu_next_state #(.PATH_W(PATH_W), .PATH_SEL(PATH_SEL)) u_ns (
    .cmd_fire    (cmd_valid),
    .op          (cmd_op),
    .lpm         (cmd_lpm),
    .cc          (cc),
    .exec_valid  (exec_valid),
    .exec_result (exec_result),
    .exec_active (exec_active),
    .cur         (cur),
    .nxt         (nxt)
  );

  assign pend_rise = nxt.stctl[0] && !cur.stctl[0];

  scu_irq_port #(.CSS_W(CSS_W), .SS_W(SS_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise     (pend_rise),
    .multi_css (cfg_multi_css),
    .cssid     (cfg_cssid),
    .ssid      (cfg_ssid),
    .irq_ready (irq_ready),
    .irq_valid (irq_valid),
    .irq_id    (irq_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur       <= '0;
      rsp_valid <= 1'b0;
      rsp_cc    <= CC_OK;
    end else begin
      cur       <= nxt;
      rsp_valid <= cmd_valid;
      if (cmd_valid) rsp_cc <= cc;
    end
  end

  assign sw_fctl   = cur.fctl;
  assign sw_actl   = cur.actl;
  assign sw_stctl  = cur.stctl;
  assign sw_dstat  = cur.dstat;
  assign sw_cstat  = cur.cstat;
  assign sw_dcc    = cur.dcc;
  assign sw_sense0 = cur.sense0;

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);
  // R2
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);
  // R2
  not_oper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !(cfg_dev_valid && cfg_enabled)) |=> (rsp_cc == CC_NOP && $stable(sw_fctl)));
  // R10
  clear_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_CLEAR && cfg_dev_valid && cfg_enabled) |=>
    (sw_fctl == 3'b100 && sw_actl == 7'd0 && sw_stctl == ST_PEND));
  // R12
  test_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_TEST && cfg_dev_valid && cfg_enabled && !sw_stctl[0]) |=>
    (rsp_cc == CC_PEND));
  // R5
  done_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && !cmd_valid && exec_result == RS_DONE && sw_fctl[0] && sw_actl[1] && !sw_stctl[0]) |=>
    (sw_stctl == (ST_PRI | ST_SEC | ST_PEND) && sw_dstat == 8'h0C && !sw_actl[1]));
endmodule

// File: tb/scu_fcu_tb_top.sv
`timescale 1ns/1ps
module scu_fcu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dev_valid = 1'b1, cfg_enabled = 1'b1, cfg_multi_css = 1'b0;
  logic [7:0] cfg_cssid = 8'h05;
  logic [1:0] cfg_ssid = 2'd1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_lpm = 8'h80;
  logic rsp_valid;
  logic [1:0] rsp_cc;
  logic exec_valid = 1'b0;
  logic [2:0] exec_result = 3'd0;
  logic exec_active = 1'b0;
  logic [2:0] sw_fctl;
  logic [6:0] sw_actl;
  logic [4:0] sw_stctl;
  logic [7:0] sw_dstat, sw_cstat, sw_sense0;
  logic [1:0] sw_dcc;
  logic irq_valid;
  logic irq_ready = 1'b0;
  logic [15:0] irq_id;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  scu_fcu dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_dev_valid(cfg_dev_valid), .cfg_enabled(cfg_enabled),
    .cfg_multi_css(cfg_multi_css), .cfg_cssid(cfg_cssid), .cfg_ssid(cfg_ssid),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_lpm(cmd_lpm),
    .rsp_valid(rsp_valid), .rsp_cc(rsp_cc),
    .exec_valid(exec_valid), .exec_result(exec_result), .exec_active(exec_active),
    .sw_fctl(sw_fctl), .sw_actl(sw_actl), .sw_stctl(sw_stctl),
    .sw_dstat(sw_dstat), .sw_cstat(sw_cstat), .sw_dcc(sw_dcc), .sw_sense0(sw_sense0),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_id(irq_id)
  );

  // ---------------- behavioural reference model ----------------
  logic [2:0] mf; logic [6:0] ma; logic [4:0] ms;
  logic [7:0] mds, mcs, msn; logic [1:0] mdcc;
  logic mrv; logic [1:0] mcc; logic mirq; logic [15:0] mid;
  logic old_pend, m_ok;
  int c;

  function automatic int ref_code(input logic [2:0] op);
    if (!m_ok || op > 3'd5) return 3;
    if (op == 3'd0) return ms[0] ? 1 : (mf != 0 ? 2 : 0);
    if (op == 3'd1) begin
      if (ms[0]) return 1;
      if (mf != 3'b001 || ma[0] || !ma[4]) return 2;
      return 0;
    end
    if (op == 3'd2) begin
      if (ms == 5'b00001 || ms[4] || ms[2] || ms[1]) return 1;
      if (mf[1] || mf[2]) return 2;
      return 0;
    end
    if (op == 3'd3) return 0;
    if (op == 3'd4) begin
      if (mf != 3'b001 || !(ma[0] || ma[1] || ma[4]) || ma[5]) return 2;
      return (ms != 0) ? 1 : 0;
    end
    return ms[0] ? 0 : 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mf = 0; ma = 0; ms = 0; mds = 0; mcs = 0; msn = 0; mdcc = 0;
      mrv = 0; mcc = 0; mirq = 0; mid = 0;
    end else begin
      old_pend = ms[0];
      m_ok = cfg_dev_valid && cfg_enabled;
      mrv = cmd_valid;
      if (cmd_valid) begin
        c = ref_code(cmd_op);
        mcc = c[1:0];
        if (c == 0) begin
          if (cmd_op == 3'd0) begin
            mf[0] = 1; ma[1] = 1;
            if (!cmd_lpm[7]) begin mdcc = 3; ms = 5'b10001; end
          end else if (cmd_op == 3'd1) begin
            ma[0] = 1;
          end else if (cmd_op == 3'd2) begin
            if (ma[5] || ma[6] || !(ma[1] || ma[4])) mds = 8'h04;
            mf[1] = 1; mf[0] = 0; ms[0] = 1;
          end else if (cmd_op == 3'd3) begin
            mf = 3'b100; ma = 0; ms = 5'b00001; mds = 0; mcs = 0; mdcc = 0;
          end else if (cmd_op == 3'd4) begin
            mf[0] = 0; ma[0] = 0; ma[1] = 0; ma[4] = 0;
          end else begin
            if (ms == 5'b01001 && !mf[1]) ma[0] = 0;
            else begin mf = 0; ma = 0; mds = 0; mcs = 0; mdcc = 0; msn = 0; end
            ms = 0;
          end
        end
      end else if (exec_valid && mf[0] && (ma[1] || ma[0]) && !ms[0] && exec_result < 3'd6) begin
        ma[0] = 0; ma[4] = 0;
        case (exec_result)
          3'd0: begin ma[1] = 0; ms = 5'b00111; mds = 8'h0C; end
          3'd1: begin ma[1] = 0; ms = 5'b10111; mds = 8'h02; msn = 8'h80; end
          3'd2: begin ma[1] = 0; ms = 5'b10111; mcs = 8'h08; end
          3'd3: begin ma[1] = 0; ms = 5'b10111; mcs = 8'h20; end
          3'd4: begin ma[1] = 0; ma[4] = 1; ms = 5'b01001; end
          default: begin mdcc = 1; ms = 5'b10001; end
        endcase
      end
      ma[5] = exec_active && (ma[1] || ma[0]);
      ma[6] = ma[5];
      if (ms[0] && !old_pend) begin
        mirq = 1;
        mid = cfg_multi_css ? ({cfg_cssid, 8'h00} | 16'h0008 | {13'd0, cfg_ssid, 1'b1})
                            : {13'd0, cfg_ssid, 1'b1};
      end else if (mirq && irq_ready) mirq = 0;
    end
  end

  task automatic expect_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      expect_eq("R3", "fctl", sw_fctl, mf);
      expect_eq("R8", "actl", sw_actl, ma);
      expect_eq("R12", "stctl", sw_stctl, ms);
      expect_eq("R5", "dstat", sw_dstat, mds);
      expect_eq("R6", "cstat/sense", {sw_cstat, sw_sense0}, {mcs, msn});
      expect_eq("R4", "dcc", sw_dcc, mdcc);
      expect_eq("R2", "rsp_valid", rsp_valid, mrv);
      if (mrv) expect_eq("R2", "rsp_cc", rsp_cc, mcc);
      expect_eq("R13", "irq_valid", irq_valid, mirq);
      if (mirq) expect_eq("R13", "irq_id", irq_id, mid);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cmd(input logic [2:0] op, input logic [7:0] lpm, output logic [1:0] cc);
    cmd_valid = 1; cmd_op = op; cmd_lpm = lpm;
    @(negedge clk);
    cmd_valid = 0;
    cc = rsp_cc;
  endtask

  task automatic outcome(input logic [2:0] r);
    exec_valid = 1; exec_result = r;
    @(negedge clk);
    exec_valid = 0;
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    logic [1:0] cc;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_eq("R1", "fctl", sw_fctl, 0);
    expect_eq("R1", "stctl", sw_stctl, 0);
    expect_eq("R1", "irq", irq_valid, 0);
    rst_n = 1;
    @(negedge clk);

    cmd(3'd5, 8'h80, cc); expect_eq("R12", "test idle cc", cc, 1);
    cmd(3'd0, 8'h80, cc); expect_eq("R3", "start cc", cc, 0);
    expect_eq("R3", "fctl", sw_fctl, 1); expect_eq("R3", "actl", sw_actl, 2);
    cmd(3'd0, 8'h80, cc); expect_eq("R3", "start busy cc", cc, 2);
    outcome(3'd0);
    expect_eq("R5", "stctl", sw_stctl, 7); expect_eq("R5", "dstat", sw_dstat, 8'h0C);
    expect_eq("R13", "irq valid", irq_valid, 1); expect_eq("R13", "irq id", irq_id, 16'h0003);
    cmd(3'd0, 8'h80, cc); expect_eq("R3", "start pend cc", cc, 1);
    expect_eq("R13", "irq held", irq_valid, 1);
    irq_ready = 1; @(negedge clk);
    expect_eq("R13", "irq taken", irq_valid, 0);
    cmd(3'd5, 8'h80, cc); expect_eq("R12", "test cc", cc, 0);
    expect_eq("R12", "fctl cleared", sw_fctl, 0);

    cmd(3'd0, 8'h40, cc); expect_eq("R4", "start cc", cc, 0);
    expect_eq("R4", "stctl", sw_stctl, 5'h11); expect_eq("R4", "dcc", sw_dcc, 3);
    outcome(3'd0); expect_eq("R7", "ignored while pending", sw_stctl, 5'h11);
    cmd(3'd5, 8'h80, cc);

    irq_ready = 0; cfg_multi_css = 1;
    cmd(3'd0, 8'h80, cc); outcome(3'd1);
    expect_eq("R6", "dstat", sw_dstat, 2); expect_eq("R6", "sense", sw_sense0, 8'h80);
    expect_eq("R6", "stctl", sw_stctl, 5'h17);
    expect_eq("R13", "multi id", irq_id, 16'h050B);
    irq_ready = 1;
    cmd(3'd5, 8'h80, cc); expect_eq("R12", "sense cleared", sw_sense0, 0);
    cmd(3'd0, 8'h80, cc); outcome(3'd2); expect_eq("R6", "data check", sw_cstat, 8'h08);
    cmd(3'd5, 8'h80, cc);
    cmd(3'd0, 8'h80, cc); outcome(3'd3); expect_eq("R6", "prog check", sw_cstat, 8'h20);
    cmd(3'd5, 8'h80, cc);

    cmd(3'd0, 8'h80, cc); outcome(3'd4);
    expect_eq("R7", "susp actl", sw_actl, 7'h10); expect_eq("R7", "susp stctl", sw_stctl, 5'h09);
    cmd(3'd5, 8'h80, cc); expect_eq("R12", "inter test cc", cc, 0);
    expect_eq("R12", "inter keeps fctl", sw_fctl, 1); expect_eq("R12", "inter keeps actl", sw_actl, 7'h10);
    cmd(3'd1, 8'h80, cc); expect_eq("R8", "resume cc", cc, 0); expect_eq("R8", "actl", sw_actl, 7'h11);
    cmd(3'd1, 8'h80, cc); expect_eq("R8", "resume again cc", cc, 2);
    outcome(3'd0); expect_eq("R8", "resumed done actl", sw_actl, 0);
    expect_eq("R8", "resumed done stctl", sw_stctl, 7);
    cmd(3'd5, 8'h80, cc);

    cmd(3'd0, 8'h80, cc); outcome(3'd4);
    cmd(3'd2, 8'h80, cc); expect_eq("R9", "halt on suspended cc", cc, 0);
    cmd(3'd5, 8'h80, cc); expect_eq("R12", "halt makes final", sw_actl, 0);

    cmd(3'd0, 8'h80, cc); outcome(3'd5);
    expect_eq("R7", "busy dcc", sw_dcc, 1); expect_eq("R7", "busy stctl", sw_stctl, 5'h11);
    expect_eq("R7", "busy actl", sw_actl, 2);
    cmd(3'd5, 8'h80, cc);
    outcome(3'd0); expect_eq("R7", "idle outcome ignored", sw_stctl, 0);

    cmd(3'd0, 8'h80, cc);
    cmd(3'd2, 8'h80, cc); expect_eq("R9", "halt cc", cc, 0);
    expect_eq("R9", "halt fctl", sw_fctl, 2); expect_eq("R9", "halt no DE", sw_dstat, 0);
    cmd(3'd5, 8'h80, cc);
    cmd(3'd2, 8'h80, cc); expect_eq("R9", "idle halt DE", sw_dstat, 4);
    cmd(3'd2, 8'h80, cc); expect_eq("R9", "halt pend cc", cc, 1);
    cmd(3'd5, 8'h80, cc);

    cmd(3'd0, 8'h80, cc);
    cmd(3'd3, 8'h80, cc); expect_eq("R10", "clear cc", cc, 0);
    expect_eq("R10", "fctl", sw_fctl, 4); expect_eq("R10", "stctl", sw_stctl, 1);
    cmd(3'd5, 8'h80, cc);

    cmd(3'd0, 8'h80, cc);
    cmd(3'd4, 8'h80, cc); expect_eq("R11", "cancel cc", cc, 0);
    expect_eq("R11", "cancel word", {sw_fctl, sw_actl}, 0);
    cmd(3'd4, 8'h80, cc); expect_eq("R11", "cancel idle cc", cc, 2);

    exec_active = 1;
    cmd(3'd0, 8'h80, cc); expect_eq("R14", "active bits", sw_actl, 7'h62);
    cmd(3'd4, 8'h80, cc); expect_eq("R11", "cancel active cc", cc, 2);
    exec_active = 0; @(negedge clk);
    expect_eq("R14", "active dropped", sw_actl, 2);

    // command and outcome in the same cycle: outcome dropped (R7)
    cmd_valid = 1; cmd_op = 3'd5; exec_valid = 1; exec_result = 3'd0;
    @(negedge clk);
    cmd_valid = 0; exec_valid = 0;
    expect_eq("R7", "collision test cc", rsp_cc, 1);
    expect_eq("R7", "collision stctl", sw_stctl, 0);
    cmd(3'd4, 8'h80, cc);

    cfg_enabled = 0;
    cmd(3'd0, 8'h80, cc); expect_eq("R2", "not oper cc", cc, 3);
    expect_eq("R2", "not oper fctl", sw_fctl, 0);
    cfg_enabled = 1;
    cmd(3'd6, 8'h80, cc); expect_eq("R2", "bad op cc", cc, 3);
    @(negedge clk); expect_eq("R2", "no rsp", rsp_valid, 0);
    finish_up();
  end
endmodule